// File: doc/BRIEF.md
# Readable Bank-Register Memory Mapper

This block lets a processor with a 64 kB address space reach up to 1 MB of physical RAM. The two most significant CPU address bits pick one of four bank registers. The chosen register supplies the upper physical address bits, and the low 14 CPU address bits pass through unchanged. Each 16 kB window of CPU space can therefore be placed on any 16 kB page of physical memory. The mapper produces a 20-bit physical address and separate chip selects for two 512 kB RAM devices. Physical bit 19 chooses between the two devices.

Software programs the mapping through a four-byte I/O window inside CPU space. A write takes effect on the falling edge of the data strobe. A read returns the value held in the addressed register, so an operating system can always find out the current mapping.

Two regions are never translated: the top 8 kB of CPU space, which holds the firmware and the reset vectors, and the mapper's own I/O window. This keeps boot code reachable and lets software reprogram the mapper however the banks are set. Each bank entry is 4 bits wide by default, which reaches the first 256 kB of the primary device. With 8-bit entries the mapper reaches both devices.

Top module: `bankmap_top`

## Requirements
- R1: After reset, bank register n holds the value n, so CPU address A in the lower 48 kB maps to physical address A.
- R2: A bank register is written only when all three of these hold at a clock edge: the data strobe was high at the previous edge, the strobe is now low, and at this edge cpu_rw is 0 and cpu_addr is IO_BASE+n. The register index n is cpu_addr[1:0]. A strobe that stays high writes nothing.
- R3: When cpu_strobe=1, cpu_rw=1 and the address is in the I/O window, rd_drive=1 and rd_data holds the addressed register, zero-extended to 8 bits. At all other times rd_drive=0 and rd_data=0.
- R4: For a RAM access, phys_addr = {bank[5:0], cpu_addr[13:0]}, where bank is the register that cpu_addr[15:14] selects. Register bits above bit 5 are ignored.
- R5: For a RAM access, exactly one RAM select is high: ram1_sel when phys_addr[19]=1, and ram0_sel otherwise.
- R6: For cpu_addr >= 16'hE000, rom_sel=1, both RAM selects are 0 and phys_addr = {7'b0, cpu_addr[12:0]}, whatever the mapping.
- R7: For cpu_addr in 16'hDFFC..16'hDFFF, io_sel=1 and the RAM and ROM selects are 0. This holds whatever register 3 contains. Address 16'hDFFB is an ordinary RAM access.
- R8: With 4-bit entries, written bits 7:4 are discarded: readback returns them as 0 and ram1_sel never rises.
- R9: A write cycle, or a read cycle, that ends outside the I/O window changes no bank register.
- R10: At most one of ram0_sel, ram1_sel, rom_sel and io_sel is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_strobe | input | 1 | Data strobe; a register write takes effect on its falling edge |
| rd_data | output | 8 | Readback of the addressed bank register |
| rd_drive | output | 1 | High while rd_data should be placed on the bus |
| phys_addr | output | 20 | Physical address |
| ram0_sel | output | 1 | Select for the primary RAM device |
| ram1_sel | output | 1 | Select for the second RAM device |
| rom_sel | output | 1 | Select for the firmware memory |
| io_sel | output | 1 | Access to the mapper's own registers |

## Verification
The bench builds two copies of the block side by side and drives them from the same bus. One uses 8-bit entries, which reaches every bank value up to 6'h3F. That takes physical bit 19 high and brings the second-device select into play, together with the masking of entry bits 7:6. The other uses the default 4-bit entries, where the same writes must lose their upper nibble and the second device must never be selected. Random write, readback and probe cycles are mixed with directed probes at the window edges, at the ROM boundary and on both sides of the I/O window.

// File: rtl/bankmap_pkg.sv
package bankmap_pkg;

   typedef enum logic [1:0] {
      RGN_RAM = 2'd0,
      RGN_ROM = 2'd1,
      RGN_IO  = 2'd2
   } region_e;

   function automatic int unsigned clog2_min1(input int unsigned n);
      int unsigned r;
      r = 0;
      while ((1 << r) < n) r++;
      return (r == 0) ? 1 : r;
   endfunction

endpackage

// File: rtl/bankmap_decode.sv
module bankmap_decode
   import bankmap_pkg::*;
#(
   parameter int unsigned     CPU_AW  = 16,
   parameter int unsigned     ROM_AW  = 13,
   parameter int unsigned     IDX_W   = 2,
   parameter logic [15:0]     IO_BASE = 16'hDFFC
) (
   input  logic [CPU_AW-1:0] addr,
   output region_e           region
);
   localparam int unsigned ROM_TAG_W = CPU_AW - ROM_AW;

   logic rom_hit;
   logic io_hit;

   assign rom_hit = &addr[CPU_AW-1:ROM_AW];
   assign io_hit  = (addr[CPU_AW-1:IDX_W] == IO_BASE[CPU_AW-1:IDX_W]);

   always_comb begin
      if (rom_hit)     region = RGN_ROM;
      else if (io_hit) region = RGN_IO;
      else             region = RGN_RAM;
   end

   generate
      if (ROM_TAG_W < 1) begin : g_bad_rom
         $error("bankmap_decode: ROM_AW must be below CPU_AW");
      end
   endgenerate

endmodule

// File: rtl/bankmap_regfile.sv
module bankmap_regfile #(
   parameter int unsigned ENTRIES = 4,
   parameter int unsigned ENTRY_W = 4,
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned IDX_W   = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [IDX_W-1:0]           wr_idx,
   input  logic [DATA_W-1:0]          wr_data,
   input  logic [IDX_W-1:0]           rd_idx,
   input  logic [IDX_W-1:0]           map_idx,
   output logic [DATA_W-1:0]          rd_val,
   output logic [ENTRY_W-1:0]         map_val,
   output logic [ENTRIES*ENTRY_W-1:0] bank_flat
);
   logic [ENTRY_W-1:0] bank_q [ENTRIES];

   genvar gi;
   generate
      for (gi = 0; gi < ENTRIES; gi++) begin : g_entry
         localparam logic [ENTRY_W-1:0] RST_VAL = ENTRY_W'(gi);
         always_ff @(posedge clk) begin
            if (!rst_n)
               bank_q[gi] <= RST_VAL;
            else if (wr_en && (wr_idx == IDX_W'(gi)))
               bank_q[gi] <= wr_data[ENTRY_W-1:0];
         end
         assign bank_flat[gi*ENTRY_W +: ENTRY_W] = bank_q[gi];
      end

      if (ENTRY_W == DATA_W) begin : g_rd_full
         assign rd_val = bank_q[rd_idx];
      end else begin : g_rd_ext
         assign rd_val = {{(DATA_W-ENTRY_W){1'b0}}, bank_q[rd_idx]};
      end
   endgenerate

   assign map_val = bank_q[map_idx];

endmodule

// File: rtl/bankmap_xlate.sv
module bankmap_xlate
   import bankmap_pkg::*;
#(
   parameter int unsigned CPU_AW  = 16,
   parameter int unsigned IDX_W   = 2,
   parameter int unsigned ENTRY_W = 4,
   parameter int unsigned PHYS_AW = 20,
   parameter int unsigned ROM_AW  = 13
) (
   input  logic [CPU_AW-1:0]  addr,
   input  region_e            region,
   input  logic [ENTRY_W-1:0] bank_val,
   output logic [PHYS_AW-1:0] phys,
   output logic               ram0_sel,
   output logic               ram1_sel,
   output logic               rom_sel,
   output logic               io_sel
);
   localparam int unsigned OFFS_W = CPU_AW - IDX_W;
   localparam int unsigned BANK_W = PHYS_AW - OFFS_W;

   logic [BANK_W-1:0]  bank_bits;
   logic [PHYS_AW-1:0] ram_phys;
   logic [PHYS_AW-1:0] rom_phys;
   logic               is_ram;

   generate
      if (ENTRY_W >= BANK_W) begin : g_trunc
         assign bank_bits = bank_val[BANK_W-1:0];
      end else begin : g_zext
         assign bank_bits = {{(BANK_W-ENTRY_W){1'b0}}, bank_val};
      end
   endgenerate

   assign ram_phys = {bank_bits, addr[OFFS_W-1:0]};
   assign rom_phys = {{(PHYS_AW-ROM_AW){1'b0}}, addr[ROM_AW-1:0]};
   assign is_ram   = (region == RGN_RAM);

   always_comb begin
      phys = (region == RGN_ROM) ? rom_phys : ram_phys;
   end

   assign ram0_sel = is_ram & ~ram_phys[PHYS_AW-1];
   assign ram1_sel = is_ram &  ram_phys[PHYS_AW-1];
   assign rom_sel  = (region == RGN_ROM);
   assign io_sel   = (region == RGN_IO);

endmodule

// File: rtl/bankmap_top.sv
module bankmap_top
   import bankmap_pkg::*;
#(
   parameter int unsigned CPU_AW  = 16,
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned ENTRIES = 4,
   parameter int unsigned ENTRY_W = 4,
   parameter int unsigned PHYS_AW = 20,
   parameter int unsigned ROM_AW  = 13,
   parameter logic [15:0] IO_BASE = 16'hDFFC
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [CPU_AW-1:0]  cpu_addr,
   input  logic [DATA_W-1:0]  cpu_wdata,
   input  logic               cpu_rw,
   input  logic               cpu_strobe,
   output logic [DATA_W-1:0]  rd_data,
   output logic               rd_drive,
   output logic [PHYS_AW-1:0] phys_addr,
   output logic               ram0_sel,
   output logic               ram1_sel,
   output logic               rom_sel,
   output logic               io_sel
);
   localparam int unsigned IDX_W  = clog2_min1(ENTRIES);
   localparam int unsigned OFFS_W = CPU_AW - IDX_W;

   generate
      if (ENTRY_W > DATA_W) begin : g_chk_w
         $error("bankmap_top: ENTRY_W exceeds DATA_W");
      end
      if (PHYS_AW <= OFFS_W) begin : g_chk_p
         $error("bankmap_top: PHYS_AW too small for the window offset");
      end
      if ((1 << IDX_W) != ENTRIES) begin : g_chk_e
         $error("bankmap_top: ENTRIES must be a power of two");
      end
      if (IO_BASE[IDX_W-1:0] != '0) begin : g_chk_io
         $error("bankmap_top: IO_BASE must be aligned to ENTRIES");
      end
   endgenerate

   region_e                    region;
   logic                       strobe_q;
   logic                       strobe_fall;
   logic                       wr_fire;
   logic [DATA_W-1:0]          rd_val;
   logic [ENTRY_W-1:0]         map_val;
   logic [ENTRIES*ENTRY_W-1:0] bank_flat;

   always_ff @(posedge clk) begin
      if (!rst_n) strobe_q <= 1'b0;
      else        strobe_q <= cpu_strobe;
   end

   assign strobe_fall = strobe_q & ~cpu_strobe;
   assign wr_fire     = strobe_fall & ~cpu_rw & (region == RGN_IO);

   bankmap_decode #(
      .CPU_AW (CPU_AW),
      .ROM_AW (ROM_AW),
      .IDX_W  (IDX_W),
      .IO_BASE(IO_BASE)
   ) u_decode (
      .addr  (cpu_addr),
      .region(region)
   );

   bankmap_regfile #(
      .ENTRIES(ENTRIES),
      .ENTRY_W(ENTRY_W),
      .DATA_W (DATA_W),
      .IDX_W  (IDX_W)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_fire),
      .wr_idx   (cpu_addr[IDX_W-1:0]),
      .wr_data  (cpu_wdata),
      .rd_idx   (cpu_addr[IDX_W-1:0]),
      .map_idx  (cpu_addr[CPU_AW-1:OFFS_W]),
      .rd_val   (rd_val),
      .map_val  (map_val),
      .bank_flat(bank_flat)
   );

   bankmap_xlate #(
      .CPU_AW (CPU_AW),
      .IDX_W  (IDX_W),
      .ENTRY_W(ENTRY_W),
      .PHYS_AW(PHYS_AW),
      .ROM_AW (ROM_AW)
   ) u_xlate (
      .addr    (cpu_addr),
      .region  (region),
      .bank_val(map_val),
      .phys    (phys_addr),
      .ram0_sel(ram0_sel),
      .ram1_sel(ram1_sel),
      .rom_sel (rom_sel),
      .io_sel  (io_sel)
   );

   assign rd_drive = cpu_strobe & cpu_rw & (region == RGN_IO);
   assign rd_data  = rd_drive ? rd_val : '0;

endmodule

// File: rtl/bankmap_checker.sv
module bankmap_checker #(
   parameter int unsigned CPU_AW  = 16,
   parameter int unsigned PHYS_AW = 20,
   parameter int unsigned FLAT_W  = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic [CPU_AW-1:0]  cpu_addr,
   input logic               cpu_rw,
   input logic               cpu_strobe,
   input logic               rd_drive,
   input logic [PHYS_AW-1:0] phys_addr,
   input logic               ram0_sel,
   input logic               ram1_sel,
   input logic               rom_sel,
   input logic               io_sel,
   input logic [FLAT_W-1:0]  bank_flat
);
   // R10: selects are mutually exclusive
   a_r10_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ram0_sel, ram1_sel, rom_sel, io_sel}));

   // R6: firmware accesses never reach RAM
   a_r6_rom_no_ram: assert property (@(posedge clk) disable iff (!rst_n)
      rom_sel |-> (!ram0_sel && !ram1_sel));

   // R3: readback drives only during a read strobe into the I/O window
   a_r3_drive_window: assert property (@(posedge clk) disable iff (!rst_n)
      rd_drive |-> (cpu_strobe && cpu_rw && io_sel));

   // R2: registers change only after a strobe that was high two samples back
   a_r2_write_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(cpu_strobe, 2) |-> $stable(bank_flat));

   // R4: the in-window offset passes through for RAM accesses
   a_r4_offset_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (ram0_sel || ram1_sel) |-> (phys_addr[CPU_AW-3:0] == cpu_addr[CPU_AW-3:0]));

   // R5: the device bit of the physical address picks the RAM device
   a_r5_device_bit: assert property (@(posedge clk) disable iff (!rst_n)
      ram1_sel |-> phys_addr[PHYS_AW-1]);

endmodule

bind bankmap_top bankmap_checker #(
   .CPU_AW (CPU_AW),
   .PHYS_AW(PHYS_AW),
   .FLAT_W (ENTRIES*ENTRY_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cpu_addr  (cpu_addr),
   .cpu_rw    (cpu_rw),
   .cpu_strobe(cpu_strobe),
   .rd_drive  (rd_drive),
   .phys_addr (phys_addr),
   .ram0_sel  (ram0_sel),
   .ram1_sel  (ram1_sel),
   .rom_sel   (rom_sel),
   .io_sel    (io_sel),
   .bank_flat (bank_flat)
);

// File: tb/test_bankmap_top.sv
module test_bankmap_top;
   localparam logic [15:0] IO_BASE = 16'hDFFC;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic [7:0]  cpu_wdata = '0;
   logic        cpu_rw = 1'b1;
   logic        cpu_strobe = 1'b0;

   logic [7:0]  w_rd, n_rd;
   logic        w_drv, n_drv;
   logic [19:0] w_phys, n_phys;
   logic        w_r0, w_r1, w_rom, w_io;
   logic        n_r0, n_r1, n_rom, n_io;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   logic [7:0] m_wide [4];
   logic [3:0] m_narrow [4];

   always #5 clk = ~clk;

   bankmap_top #(.ENTRY_W(8)) i_bankmap_top (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_rw(cpu_rw), .cpu_strobe(cpu_strobe), .rd_data(w_rd), .rd_drive(w_drv),
      .phys_addr(w_phys), .ram0_sel(w_r0), .ram1_sel(w_r1), .rom_sel(w_rom), .io_sel(w_io));

   bankmap_top #(.ENTRY_W(4)) i_bankmap_top_narrow (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_rw(cpu_rw), .cpu_strobe(cpu_strobe), .rd_data(n_rd), .rd_drive(n_drv),
      .phys_addr(n_phys), .ram0_sel(n_r0), .ram1_sel(n_r1), .rom_sel(n_rom), .io_sel(n_io));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [23:0] expect_map(input logic [15:0] a, input logic [7:0] bank);
      // returns {io, rom, ram1, ram0, phys[19:0]}
      logic [19:0] p;
      if (a >= 16'hE000) return {4'b0100, 7'b0, a[12:0]};
      if (a[15:2] == IO_BASE[15:2]) return {4'b1000, 20'h0};
      p = {bank[5:0], a[13:0]};
      return {2'b00, p[19], ~p[19], p};
   endfunction

   task automatic probe(input logic [15:0] a, input string req);
      logic [23:0] ew, en;
      @(negedge clk);
      cpu_addr = a; cpu_rw = 1'b1; cpu_strobe = 1'b1;
      #1;
      ew = expect_map(a, m_wide[a[15:14]]);
      en = expect_map(a, {4'h0, m_narrow[a[15:14]]});
      chk({req, " sel wide"},   {28'h0, w_io, w_rom, w_r1, w_r0}, {28'h0, ew[23:20]});
      chk({req, " sel narrow"}, {28'h0, n_io, n_rom, n_r1, n_r0}, {28'h0, en[23:20]});
      if (!ew[23]) chk({req, " phys wide"},   {12'h0, w_phys}, {12'h0, ew[19:0]});
      if (!en[23]) chk({req, " phys narrow"}, {12'h0, n_phys}, {12'h0, en[19:0]});
   endtask

   task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      cpu_addr = a; cpu_wdata = d; cpu_rw = 1'b0; cpu_strobe = 1'b1;
      @(negedge clk);
      cpu_strobe = 1'b0;
      @(negedge clk);
      cpu_rw = 1'b1;
      if (a[15:2] == IO_BASE[15:2]) begin
         m_wide[a[1:0]]   = d;
         m_narrow[a[1:0]] = d[3:0];
      end
   endtask

   task automatic read_check(input int idx, input string req);
      @(negedge clk);
      cpu_addr = IO_BASE + 16'(idx); cpu_rw = 1'b1; cpu_strobe = 1'b1;
      #1;
      chk({req, " drive wide"},   {31'h0, w_drv}, 32'h1);
      chk({req, " data wide"},    {24'h0, w_rd}, {24'h0, m_wide[idx]});
      chk({req, " data narrow"},  {24'h0, n_rd}, {28'h0, m_narrow[idx]});
      @(negedge clk);
      cpu_strobe = 1'b0;
      #1;
      chk("R3 drive low after strobe", {30'h0, w_drv, n_drv}, 32'h0);
      chk("R3 data zero after strobe", {16'h0, w_rd, n_rd}, 32'h0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      for (int i = 0; i < 4; i++) begin
         m_wide[i] = 8'(i); m_narrow[i] = 4'(i);
      end
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;

      // R1: reset contents and identity mapping
      for (int i = 0; i < 4; i++) read_check(i, "R1 reset readback");
      probe(16'h0000, "R1 identity");
      probe(16'h4123, "R1 identity");
      probe(16'hBFFF, "R1 identity");

      // R6 / R7: fixed regions
      probe(16'hE000, "R6 rom low edge");
      probe(16'hFFFF, "R6 rom top");
      probe(16'hDFFF, "R7 io top");
      probe(16'hDFFC, "R7 io base");
      probe(16'hDFFB, "R7 below io is ram");

      // R8 / R5: full byte into entry 2
      bus_write(IO_BASE + 16'd2, 8'hFF);
      read_check(2, "R8 upper nibble");
      probe(16'h8000, "R5 device one");
      probe(16'hBFFF, "R4 window top");

      // R7: io window stays fixed even when entry 3 is remapped
      bus_write(IO_BASE + 16'd3, 8'h20);
      probe(16'hDFFD, "R7 io after remap");
      probe(16'hC000, "R4 remapped window");
      probe(16'hE123, "R6 rom after remap");

      // R9: write outside window and read cycle in window change nothing
      bus_write(16'h1FFE, 8'hAA);
      for (int i = 0; i < 4; i++) read_check(i, "R9 no stray write");

      // R2: held strobe does not write
      @(negedge clk);
      cpu_addr = IO_BASE; cpu_wdata = 8'h3C; cpu_rw = 1'b0; cpu_strobe = 1'b1;
      repeat (3) @(negedge clk);
      cpu_rw = 1'b1;
      #1;
      chk("R2 held strobe no write", {24'h0, w_rd}, 32'h0);
      cpu_strobe = 1'b0;
      read_check(0, "R2 held strobe no write");

      // random mix
      for (int k = 0; k < 400; k++) begin
         int unsigned op;
         op = $urandom_range(0, 3);
         case (op)
            0: bus_write(IO_BASE + 16'($urandom_range(0, 3)), 8'($urandom));
            1: read_check($urandom_range(0, 3), "R3 random readback");
            2: bus_write(16'($urandom_range(0, 16'hDFF0)), 8'($urandom));
            default: probe(16'($urandom), "R4 random probe");
         endcase
      end

      @(negedge clk);
      cpu_strobe = 1'b0;
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule